// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the byte-wide register file of an interrupt distributor that serves up to `NUM_SRC` sources (96 by default). Software reaches it through a single-byte access strobe carrying a 12-bit offset. The offset selects one of these: a global enable, a read-only size register, bit banks that set or clear enables, bit banks that set or clear pending flags, a read-only view of the active flags, one priority byte and one target byte per source, a two-bit configuration field per source, and a read-only identification area. The block drives the enable, pending, priority, target and configuration state out to the priority selector that sits next to it.

External interrupt lines are also watched. Line `n` belongs to source `n+32`. Each source's trigger mode, together with its enable, decides whether a rising level becomes a pending flag. An access to an offset that is unmapped, that lies beyond the implemented sources, or that writes a read-only area is answered with an error flag and changes nothing.

Every access is accepted in the cycle its strobe is high. There is no back-pressure: `bus_sel` has no ready partner. The response comes out on the next cycle as a one-cycle `rsp_valid` pulse with read data and the error flag. Read data always shows the state as it was before any write in the same cycle.

Top module: `irq_dist_regs`

## Requirements
- R1: Offset 0x000 bit 0 holds the global enable, which is driven on `dist_en` and reads back. Offset 0x004 reads `NUM_SRC/32 - 1` (2 by default). Offsets 0x001–0x003 and 0x005–0x007 read 0. Writes to 0x001–0x007 are ignored without error.
- R2: A write to 0x100+g sets the enable of source 8g+b for each bit b that is 1. A write to 0x180+g clears it the same way. A 0 bit has no effect. Both offsets read the enable byte of group g.
- R3: Offsets 0x200+g (set) and 0x280+g (clear) act on the pending flags with the same rule as R2. Both read the pending byte of group g.
- R4: A read of 0x300+g returns `act_in[8g+7:8g]`. Any write to 0x300–0x3FF is an error.
- R5: Offset 0x400+n holds the priority byte of source n and 0x800+n holds its target byte. Both are read/write and appear on `src_prio` and `src_tgt` at bits [8n+7:8n].
- R6: Byte 0xC00+k holds the fields of sources 4k+j (j = 0..3). Bit 2j is the model bit. Bit 2j+1 is the trigger bit: 1 means edge, 0 means level. Reads use the same mapping.
- R7: Setting the enable of a level-triggered source whose recorded line level is high also sets its pending flag.
- R8: On a rising line, the level is recorded and pending is set if the source is edge-triggered or enabled. On a falling line only the recorded level clears. A line that holds its value causes nothing.
- R9: A read of 0xFE0+4w (w = 0..7) returns `ID_BASE + w` (0xC0 + w by default). Unaligned offsets in that area read 0.
- R10: These accesses set `rsp_err` and leave all state unchanged: offsets 0x008–0x0FF and 0xF00–0xFDF, bank bytes for group g ≥ NUM_SRC/8, priority and target bytes for n ≥ NUM_SRC, configuration bytes for k ≥ NUM_SRC/4, and writes to 0xFE0 and above.
- R11: One cycle after each strobe, `rsp_valid` is high for one cycle. `rsp_rdata` carries the read data, or 0 for a write. `rsp_valid` is low in any cycle that does not follow a strobe.
- R12: If a clear-pending write and a rising line that would set pending land in the same cycle, the flag ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one byte per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after the strobe |
| rsp_rdata | output | 8 | Read data |
| rsp_err | output | 1 | Invalid access flag |
| irq_lines | input | NUM_SRC-32 | External lines; line n drives source n+32 |
| act_in | input | NUM_SRC | Active flags from the selector |
| dist_en | output | 1 | Global enable |
| src_en | output | NUM_SRC | Enable per source |
| src_pend | output | NUM_SRC | Pending per source |
| src_prio | output | 8*NUM_SRC | Priority bytes |
| src_tgt | output | 8*NUM_SRC | Target bytes |
| src_model | output | NUM_SRC | Model bit per source |
| src_edge | output | NUM_SRC | Trigger bit per source (1 = edge) |

## Verification
The bench drives lines on an edge-triggered disabled source, a level-triggered disabled source and a level-triggered enabled source. This separates the rule "edge or enabled sets pending" from a rule that looks at only one of the two. A line is dropped, and another held high after its flag is cleared, to show that only a rising level acts. Enabling a level source while its line is already high checks the late-enable path apart from the line path. Bank writes mix 1 and 0 bits, and out-of-range offsets sit just past each bank's last valid byte, so an off-by-one in the decode or in the bit mapping shows up.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  typedef enum logic [3:0] {
    RG_CTRL, RG_TYPE, RG_RSVD, RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD,
    RG_ACT, RG_PRIO, RG_TGT, RG_CFG, RG_ID, RG_NONE
  } region_e;

  typedef struct packed {
    region_e    rg;
    logic [9:0] idx;
    logic       err;
  } dec_t;
endpackage

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
  import irq_dist_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic [11:0] addr,
  input  logic        wr,
  output dec_t        dec
);
  localparam logic [9:0] NGRP = 10'(NUM_SRC / 8);
  localparam logic [9:0] NSRC = 10'(NUM_SRC);
  localparam logic [9:0] NCFG = 10'(NUM_SRC / 4);

  logic oor;

  always_comb begin
    dec.rg  = RG_NONE;
    dec.idx = '0;
    if (addr < 12'h008) begin
      dec.idx = {7'd0, addr[2:0]};
      if (addr == 12'h000)      dec.rg = RG_CTRL;
      else if (addr == 12'h004) dec.rg = RG_TYPE;
      else                      dec.rg = RG_RSVD;
    end else if (addr < 12'h100) begin
      dec.rg = RG_NONE;
    end else if (addr < 12'h180) begin
      dec.rg = RG_SETEN; dec.idx = {3'd0, addr[6:0]};
    end else if (addr < 12'h200) begin
      dec.rg = RG_CLREN; dec.idx = {3'd0, addr[6:0]};
    end else if (addr < 12'h280) begin
      dec.rg = RG_SETPD; dec.idx = {3'd0, addr[6:0]};
    end else if (addr < 12'h300) begin
      dec.rg = RG_CLRPD; dec.idx = {3'd0, addr[6:0]};
    end else if (addr < 12'h400) begin
      dec.rg = RG_ACT;   dec.idx = {2'd0, addr[7:0]};
    end else if (addr < 12'h800) begin
      dec.rg = RG_PRIO;  dec.idx = addr[9:0];
    end else if (addr < 12'hC00) begin
      dec.rg = RG_TGT;   dec.idx = addr[9:0];
    end else if (addr < 12'hF00) begin
      dec.rg = RG_CFG;   dec.idx = 10'(addr - 12'hC00);
    end else if (addr < 12'hFE0) begin
      dec.rg = RG_NONE;
    end else begin
      dec.rg = RG_ID;    dec.idx = {5'd0, addr[4:0]};
    end
  end

  always_comb begin
    case (dec.rg)
      RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD, RG_ACT: oor = (dec.idx >= NGRP);
      RG_PRIO, RG_TGT:                                oor = (dec.idx >= NSRC);
      RG_CFG:                                         oor = (dec.idx >= NCFG);
      default:                                        oor = 1'b0;
    endcase
    dec.err = (dec.rg == RG_NONE) | oor | (wr & ((dec.rg == RG_ACT) | (dec.rg == RG_ID)));
  end
endmodule

// File: rtl/irq_dist_bits.sv
module irq_dist_bits
  import irq_dist_pkg::*;
#(
  parameter int NUM_SRC = 96,
  localparam int NUM_LINES = NUM_SRC - 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ok,
  input  region_e              rg,
  input  logic [9:0]           idx,
  input  logic [7:0]           wdata,
  input  logic [NUM_SRC-1:0]   trig,
  input  logic [NUM_LINES-1:0] lines,
  output logic [NUM_SRC-1:0]   en_q,
  output logic [NUM_SRC-1:0]   pend_q
);
  logic [NUM_SRC-1:0] lvl_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int GRP = i / 8;
    localparam int BIT = i % 8;
    logic hit, se, ce, sp, cp, line_in, rise, fall;

    assign hit  = wr_ok & (idx == 10'(GRP)) & wdata[BIT];
    assign se   = hit & (rg == RG_SETEN);
    assign ce   = hit & (rg == RG_CLREN);
    assign sp   = hit & (rg == RG_SETPD);
    assign cp   = hit & (rg == RG_CLRPD);

    if (i >= 32) begin : g_line
      assign line_in = lines[i-32];
    end else begin : g_noline
      assign line_in = 1'b0;
    end

    assign rise = line_in & ~lvl_q[i];
    assign fall = ~line_in & lvl_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[i]  <= 1'b0;
        en_q[i]   <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        lvl_q[i] <= line_in;
        if (se)      en_q[i] <= 1'b1;
        else if (ce) en_q[i] <= 1'b0;
        pend_q[i] <= (pend_q[i]
                      | (rise & (trig[i] | en_q[i]))
                      | (se & lvl_q[i] & ~trig[i])
                      | sp) & ~cp;
      end
    end

    assert_clr_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cp |=> !pend_q[i]) else $error("clear-pending ignored");
    assert_set_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
      se |=> en_q[i]) else $error("set-enable ignored");
    assert_late_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (se & lvl_q[i] & ~trig[i] & ~cp) |=> pend_q[i]) else $error("late enable lost");
    assert_edge_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rise & trig[i] & ~cp) |=> pend_q[i]) else $error("edge rise lost");
    assert_fall_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fall & ~sp & ~cp & ~se) |=> (pend_q[i] == $past(pend_q[i])))
      else $error("fall changed pending");
  end
endmodule

// File: rtl/irq_dist_bytes.sv
module irq_dist_bytes
  import irq_dist_pkg::*;
#(
  parameter int NUM_SRC = 96,
  localparam int NCFG = NUM_SRC / 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_ok,
  input  region_e                rg,
  input  logic [9:0]             idx,
  input  logic [7:0]             wdata,
  output logic [NUM_SRC*8-1:0]   prio_flat,
  output logic [NUM_SRC*8-1:0]   tgt_flat,
  output logic [NUM_SRC-1:0]     model_q,
  output logic [NUM_SRC-1:0]     trig_q,
  output logic [7:0]             rd_prio,
  output logic [7:0]             rd_tgt,
  output logic [7:0]             rd_cfg
);
  logic [7:0] prio_q [NUM_SRC];
  logic [7:0] tgt_q  [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int CB = i / 4;
    localparam int CJ = i % 4;
    logic sel_b, sel_c;
    assign sel_b = wr_ok & (idx == 10'(i));
    assign sel_c = wr_ok & (rg == RG_CFG) & (idx == 10'(CB));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[i]  <= '0;
        tgt_q[i]   <= '0;
        model_q[i] <= 1'b0;
        trig_q[i]  <= 1'b0;
      end else begin
        if (sel_b && rg == RG_PRIO) prio_q[i] <= wdata;
        if (sel_b && rg == RG_TGT)  tgt_q[i]  <= wdata;
        if (sel_c) begin
          model_q[i] <= wdata[2*CJ];
          trig_q[i]  <= wdata[2*CJ+1];
        end
      end
    end

    assign prio_flat[8*i +: 8] = prio_q[i];
    assign tgt_flat[8*i +: 8]  = tgt_q[i];
  end

  always_comb begin
    rd_prio = '0;
    rd_tgt  = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (idx == 10'(k)) begin
        rd_prio = prio_q[k];
        rd_tgt  = tgt_q[k];
      end
    end
  end

  always_comb begin
    rd_cfg = '0;
    for (int k = 0; k < NCFG; k++) begin
      if (idx == 10'(k)) begin
        for (int j = 0; j < 4; j++) begin
          rd_cfg[2*j]   = model_q[4*k+j];
          rd_cfg[2*j+1] = trig_q[4*k+j];
        end
      end
    end
  end

  assert_cfg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rg == RG_CFG && idx == 10'd0) |=> (trig_q[0] == $past(wdata[1])))
    else $error("config write lost");
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int         NUM_SRC = 96,
  parameter logic [7:0] ID_BASE = 8'hC0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [11:0]           bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic                  rsp_valid,
  output logic [7:0]            rsp_rdata,
  output logic                  rsp_err,
  input  logic [NUM_SRC-33:0]   irq_lines,
  input  logic [NUM_SRC-1:0]    act_in,
  output logic                  dist_en,
  output logic [NUM_SRC-1:0]    src_en,
  output logic [NUM_SRC-1:0]    src_pend,
  output logic [NUM_SRC*8-1:0]  src_prio,
  output logic [NUM_SRC*8-1:0]  src_tgt,
  output logic [NUM_SRC-1:0]    src_model,
  output logic [NUM_SRC-1:0]    src_edge
);
  localparam int         NGRP     = NUM_SRC / 8;
  localparam logic [7:0] TYPE_VAL = 8'(NUM_SRC / 32 - 1);

  dec_t       dec;
  logic       wr_ok;
  logic [7:0] rd_prio, rd_tgt, rd_cfg, rd_mux;
  logic       ctrl_q;

  irq_dist_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .dec(dec)
  );

  assign wr_ok = bus_sel & bus_wr & ~dec.err;

  irq_dist_bits #(.NUM_SRC(NUM_SRC)) u_bits (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rg(dec.rg), .idx(dec.idx),
    .wdata(bus_wdata), .trig(src_edge), .lines(irq_lines),
    .en_q(src_en), .pend_q(src_pend)
  );

  irq_dist_bytes #(.NUM_SRC(NUM_SRC)) u_bytes (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rg(dec.rg), .idx(dec.idx),
    .wdata(bus_wdata), .prio_flat(src_prio), .tgt_flat(src_tgt),
    .model_q(src_model), .trig_q(src_edge),
    .rd_prio(rd_prio), .rd_tgt(rd_tgt), .rd_cfg(rd_cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 ctrl_q <= 1'b0;
    else if (wr_ok && dec.rg == RG_CTRL)        ctrl_q <= bus_wdata[0];
  end
  assign dist_en = ctrl_q;

  always_comb begin
    rd_mux = '0;
    case (dec.rg)
      RG_CTRL: rd_mux = {7'd0, ctrl_q};
      RG_TYPE: rd_mux = TYPE_VAL;
      RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD, RG_ACT: begin
        for (int g = 0; g < NGRP; g++) begin
          if (dec.idx == 10'(g)) begin
            if (dec.rg == RG_SETEN || dec.rg == RG_CLREN)      rd_mux = src_en[8*g +: 8];
            else if (dec.rg == RG_SETPD || dec.rg == RG_CLRPD) rd_mux = src_pend[8*g +: 8];
            else                                               rd_mux = act_in[8*g +: 8];
          end
        end
      end
      RG_PRIO: rd_mux = rd_prio;
      RG_TGT:  rd_mux = rd_tgt;
      RG_CFG:  rd_mux = rd_cfg;
      RG_ID:   rd_mux = (dec.idx[1:0] == 2'd0) ? (ID_BASE + 8'(dec.idx[4:2])) : 8'd0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= bus_sel;
      rsp_err   <= bus_sel & dec.err;
      rsp_rdata <= (bus_sel && !bus_wr && !dec.err) ? rd_mux : 8'd0;
    end
  end

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> rsp_valid) else $error("missing response");
  assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !rsp_valid) else $error("spurious response");
  assert_err_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel & bus_wr & dec.err) |=> ($stable(src_en) && $stable(dist_en)
                                      && $stable(src_prio) && $stable(src_edge)))
    else $error("error write changed state");
  assert_err_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel & dec.err) |=> rsp_err) else $error("error flag missing");
endmodule

// File: tb/irq_dist_regs_tb.sv
module irq_dist_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 96;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic rsp_valid, rsp_err;
  logic [7:0] rsp_rdata;
  logic [NS-33:0] irq_lines = '0;
  logic [NS-1:0] act_in = '0;
  logic dist_en;
  logic [NS-1:0] src_en, src_pend, src_model, src_edge;
  logic [NS*8-1:0] src_prio, src_tgt;

  int checks = 0, errors = 0;
  logic [NS-1:0] exp_en = '0, exp_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dist_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_lines(irq_lines),
    .act_in(act_in), .dist_en(dist_en), .src_en(src_en), .src_pend(src_pend),
    .src_prio(src_prio), .src_tgt(src_tgt), .src_model(src_model), .src_edge(src_edge)
  );

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [11:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output logic er);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    chk("R11 valid", 128'(rsp_valid), 128'(1));
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic wr_ok(input logic [11:0] a, input logic [7:0] d, input string req);
    logic [7:0] r; logic e;
    acc(1, a, d, r, e);
    chk(req, 128'(e), 128'(0));
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [7:0] x, input string req);
    logic [7:0] r; logic e;
    acc(0, a, 0, r, e);
    chk(req, 128'({e, r}), 128'({1'b0, x}));
  endtask

  task automatic bad(input logic wr, input logic [11:0] a, input string req);
    logic [7:0] r; logic e;
    acc(wr, a, 8'hFF, r, e);
    chk(req, 128'(e), 128'(1));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 idle", 128'(rsp_valid), 128'(0));
    chk("R1 reset en", 128'(dist_en), 128'(0));
    chk("R2 reset", 128'(src_en), 128'(0));
    chk("R3 reset", 128'(src_pend), 128'(0));
    rd_exp(12'h000, 8'h00, "R1 reset read");
  endtask

  task automatic t_ctrl;
    wr_ok(12'h000, 8'hFF, "R1 write");
    chk("R1 dist_en", 128'(dist_en), 128'(1));
    rd_exp(12'h000, 8'h01, "R1 readback");
    rd_exp(12'h004, 8'h02, "R1 type");
    rd_exp(12'h003, 8'h00, "R1 rsvd");
    wr_ok(12'h005, 8'hFF, "R1 rsvd write");
    rd_exp(12'h005, 8'h00, "R1 rsvd after");
    wr_ok(12'h004, 8'hFF, "R1 type write");
    rd_exp(12'h004, 8'h02, "R1 type after");
  endtask

  task automatic t_enable;
    wr_ok(12'h101, 8'h05, "R2 set");
    exp_en[8] = 1; exp_en[10] = 1;
    chk("R2 set vec", 128'(src_en), 128'(exp_en));
    wr_ok(12'h181, 8'h01, "R2 clr");
    exp_en[8] = 0;
    chk("R2 clr vec", 128'(src_en), 128'(exp_en));
    wr_ok(12'h101, 8'h00, "R2 zero");
    chk("R2 zero no effect", 128'(src_en), 128'(exp_en));
    rd_exp(12'h101, 8'h04, "R2 read set");
    rd_exp(12'h181, 8'h04, "R2 read clr");
    wr_ok(12'h181, 8'h04, "R2 clr10");
    exp_en[10] = 0;
    chk("R2 all clear", 128'(src_en), 128'(exp_en));
  endtask

  task automatic t_pending;
    wr_ok(12'h20B, 8'h81, "R3 set");
    exp_pend[95] = 1; exp_pend[88] = 1;
    chk("R3 set vec", 128'(src_pend), 128'(exp_pend));
    rd_exp(12'h28B, 8'h81, "R3 read");
    wr_ok(12'h28B, 8'h80, "R3 clr");
    exp_pend[95] = 0;
    chk("R3 clr vec", 128'(src_pend), 128'(exp_pend));
    wr_ok(12'h28B, 8'h01, "R3 clr2");
    exp_pend[88] = 0;
    rd_exp(12'h20B, 8'h00, "R3 read empty");
  endtask

  task automatic t_active;
    act_in = '0; act_in[17] = 1; act_in[22] = 1;
    rd_exp(12'h302, 8'h42, "R4 read");
    bad(1, 12'h302, "R4 write err");
  endtask

  task automatic t_bytes;
    wr_ok(12'h45F, 8'hA5, "R5 prio");
    chk("R5 prio out", 128'(src_prio[8*95 +: 8]), 128'(8'hA5));
    rd_exp(12'h45F, 8'hA5, "R5 prio read");
    wr_ok(12'h800, 8'h3C, "R5 tgt");
    chk("R5 tgt out", 128'(src_tgt[7:0]), 128'(8'h3C));
    rd_exp(12'h800, 8'h3C, "R5 tgt read");
  endtask

  task automatic t_cfg;
    wr_ok(12'hC09, 8'h08, "R6 cfg");
    chk("R6 edge37", 128'(src_edge), 128'(96'(1) << 37));
    wr_ok(12'hC0A, 8'h01, "R6 model");
    chk("R6 model40", 128'(src_model), 128'(96'(1) << 40));
    rd_exp(12'hC09, 8'h08, "R6 read");
    rd_exp(12'hC0A, 8'h01, "R6 read2");
  endtask

  task automatic t_lines;
    @(negedge clk); irq_lines[5] = 1;  // source 37, edge, disabled
    @(negedge clk); @(negedge clk);
    exp_pend[37] = 1;
    chk("R8 edge rise", 128'(src_pend), 128'(exp_pend));
    wr_ok(12'h284, 8'h20, "R8 clr37");
    exp_pend[37] = 0;
    irq_lines[5] = 0;
    @(negedge clk); @(negedge clk);
    chk("R8 fall no pend", 128'(src_pend), 128'(exp_pend));
    irq_lines[8] = 1;                  // source 40, level, disabled
    @(negedge clk); @(negedge clk);
    chk("R8 level disabled", 128'(src_pend), 128'(exp_pend));
    wr_ok(12'h105, 8'h01, "R7 enable40");
    exp_en[40] = 1; exp_pend[40] = 1;
    chk("R7 late enable", 128'(src_pend), 128'(exp_pend));
    irq_lines[8] = 0;
    @(negedge clk); @(negedge clk);
    chk("R8 fall keeps", 128'(src_pend), 128'(exp_pend));
    wr_ok(12'h285, 8'h01, "R8 clr40");
    exp_pend[40] = 0;
    wr_ok(12'h105, 8'h02, "R8 enable41");
    exp_en[41] = 1;
    irq_lines[9] = 1;                  // source 41, level, enabled
    @(negedge clk); @(negedge clk);
    exp_pend[41] = 1;
    chk("R8 enabled rise", 128'(src_pend), 128'(exp_pend));
    wr_ok(12'h285, 8'h02, "R8 clr41");
    exp_pend[41] = 0;
    repeat (3) @(negedge clk);
    chk("R8 held ignored", 128'(src_pend), 128'(exp_pend));
    chk("R2 en vec", 128'(src_en), 128'(exp_en));
  endtask

  task automatic t_race;
    irq_lines[5] = 0;
    @(negedge clk); @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 12'h284; bus_wdata = 8'h20;
    irq_lines[5] = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    @(negedge clk);
    chk("R12 clear wins", 128'(src_pend[37]), 128'(0));
  endtask

  task automatic t_id;
    rd_exp(12'hFE0, 8'hC0, "R9 id0");
    rd_exp(12'hFE4, 8'hC1, "R9 id1");
    rd_exp(12'hFFC, 8'hC7, "R9 id7");
    rd_exp(12'hFE1, 8'h00, "R9 unaligned");
  endtask

  task automatic t_err;
    bad(1, 12'h10C, "R10 en oor");
    chk("R10 en unchanged", 128'(src_en), 128'(exp_en));
    bad(1, 12'h460, "R10 prio oor");
    chk("R10 prio unchanged", 128'(src_prio[8*95 +: 8]), 128'(8'hA5));
    bad(0, 12'h460, "R10 prio read oor");
    bad(0, 12'h008, "R10 gap");
    bad(1, 12'hF00, "R10 f00");
    bad(1, 12'hFE0, "R10 id write");
    bad(0, 12'hC18, "R10 cfg oor");
    bad(1, 12'h28C, "R10 pend oor");
    chk("R10 dist_en kept", 128'(dist_en), 128'(1));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_ctrl;
    t_enable;
    t_pending;
    t_active;
    t_bytes;
    t_cfg;
    t_lines;
    t_race;
    t_id;
    t_err;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule